// File: doc/BRIEF.md
# Cache Slice ECC Error Logger

This block records ECC events for one cache slice. Single-cycle pulses report corrected and uncorrected errors from three storage stages: request, tag and data. Each error class also supplies the address that was involved. The block keeps sticky per-stage flags and counts every error event. A second counter counts only events whose address differs from the last one captured. The block also holds the most recent error address and drives one level interrupt for each error class.

Software reaches the block through a small word-addressed register port. Reads are combinational. A write takes effect on the next rising clock edge. Software clears a class's counters by writing zero to that class's count register. It clears all status flags by writing a command bit to the status register.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, all four registers read 0, and both interrupt outputs are low.
- R2: An event sets a sticky status flag. Uncorrected flags sit at bit 0 (request stage), bit 2 (tag stage) and bit 4 (data stage). Corrected flags sit at bit 1 (request stage), bit 3 (tag stage) and bit 5 (data stage). Event input bit 0 is the request stage, bit 1 the tag stage and bit 2 the data stage.
- R3: The total counter of a class increases by one in each cycle where any stage of that class reports an event. In the corrected count register (offset 1) and the uncorrected count register (offset 2), bits 15:0 hold the total count and bits 31:16 hold the unique count.
- R4: The unique counter of a class increases only in two cases: no address has been captured since reset, or the event address differs from the captured address of the previous cycle.
- R5: The address register (offset 3) takes the address of the latest event. When both classes report an event in the same cycle, the uncorrected address is stored.
- R6: When corrected and uncorrected events arrive in the same cycle, both classes count them.
- R7: When a counter wraps from 0xFFFF to 0, its overflow flag is set. The flags are bit 16 for the corrected total, bit 17 for the corrected unique, bit 18 for the uncorrected total and bit 19 for the uncorrected unique counter. An overflow flag stays set until a status reset, even if the counters are cleared.
- R8: Writing zero to a count register clears both of its counters. A nonzero write to a count register has no effect.
- R9: Writing the status register (offset 0) with bit 30 set clears all stage flags and overflow flags. A status write with bit 30 clear has no effect. Bit 30 always reads 0.
- R10: The corrected interrupt is high while any corrected stage flag or corrected overflow flag is set. The uncorrected interrupt follows the uncorrected flags in the same way. Both interrupts drop in the cycle after a status reset.
- R11: The address register is read-only: writes to offset 3 do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cor_evt_i | input | 3 | Corrected event pulses for the request, tag and data stages |
| cor_addr_i | input | 32 | Address of the corrected event |
| unc_evt_i | input | 3 | Uncorrected event pulses for the request, tag and data stages |
| unc_addr_i | input | 32 | Address of the uncorrected event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the register at reg_sel_i |
| irq_cor_o | output | 1 | Corrected-error interrupt level |
| irq_unc_o | output | 1 | Uncorrected-error interrupt level |

## Verification
The assertions assume that event pulses are sampled once per rising edge. They also assume that a cycle with a write strobe has a stable offset and stable data. The properties on interrupt drop and address hold apply only in cycles with no new event, because a fresh event would legitimately set the flag or address again. The directed stimulus keeps writes and events in separate cycles, except where a scenario deliberately combines both error classes. It drives every input on the falling edge, so the inputs are always settled at the sampling edge.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    localparam int NUM_STAGES    = 3;
    localparam int NUM_CLASSES   = 2;
    localparam int CLS_COR       = 0;
    localparam int CLS_UNC       = 1;
    localparam int STS_OVF_LSB   = 16;
    localparam int STS_RESET_BIT = 30;
    localparam int FIELD_W       = 16;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_CORCNT = 2'd1,
        REG_UNCCNT = 2'd2,
        REG_ADDR   = 2'd3
    } ecc_reg_e;

    typedef struct packed {
        logic [2*NUM_CLASSES-1:0] ovf;
        logic [NUM_STAGES-1:0]    cor;
        logic [NUM_STAGES-1:0]    unc;
    } ecc_status_t;
endpackage

// File: rtl/ecc_err_counter.sv
module ecc_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             hit_i,
    input  logic             new_i,
    output logic [CNT_W-1:0] total_o,
    output logic [CNT_W-1:0] uniq_o,
    output logic             total_wrap_o,
    output logic             uniq_wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] uniq;
    } cnt_t;

    cnt_t             st_d, st_q;
    logic [CNT_W-1:0] tot_base, uq_base;

    always_comb begin
        tot_base     = clr_i ? '0 : st_q.total;
        uq_base      = clr_i ? '0 : st_q.uniq;
        st_d.total   = tot_base + {{(CNT_W-1){1'b0}}, hit_i};
        st_d.uniq    = uq_base + {{(CNT_W-1){1'b0}}, new_i};
        total_wrap_o = hit_i && (&tot_base);
        uniq_wrap_o  = new_i && (&uq_base);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total_o = st_q.total;
    assign uniq_o  = st_q.uniq;

    // R3: one step per event cycle
    p_total_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && hit_i) |=> (total_o == $past(total_o) + CNT_W'(1)));
    // R4: unique count holds without a new address
    p_uniq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !new_i) |=> $stable(uniq_o));
    // R8: clear empties both fields
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_i) |=> (total_o == '0 && uniq_o == '0));
endmodule

// File: rtl/ecc_addr_tracker.sv
module ecc_addr_tracker #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cor_hit_i,
    input  logic [ADDR_W-1:0] cor_addr_i,
    input  logic              unc_hit_i,
    input  logic [ADDR_W-1:0] unc_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cor_new_o,
    output logic              unc_new_o
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        cor_new_o = cor_hit_i && (!trk_q.vld || cor_addr_i != trk_q.addr);
        unc_new_o = unc_hit_i && (!trk_q.vld || unc_addr_i != trk_q.addr);
        if (unc_hit_i) begin
            trk_d.vld  = 1'b1;
            trk_d.addr = unc_addr_i;
        end else if (cor_hit_i) begin
            trk_d.vld  = 1'b1;
            trk_d.addr = cor_addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign addr_o = trk_q.addr;

    // R5: uncorrected address wins capture
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unc_hit_i |=> (addr_o == $past(unc_addr_i)));
    // R11: address only moves on events
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cor_hit_i && !unc_hit_i) |=> $stable(addr_o));
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] cor_evt_i,
    input  logic [ADDR_W-1:0]     cor_addr_i,
    input  logic [NUM_STAGES-1:0] unc_evt_i,
    input  logic [ADDR_W-1:0]     unc_addr_i,
    input  logic                  reg_wr_i,
    input  logic [1:0]            reg_sel_i,
    input  logic [31:0]           reg_wdata_i,
    output logic [31:0]           reg_rdata_o,
    output logic                  irq_cor_o,
    output logic                  irq_unc_o
);
    localparam int OVF_W = 2 * NUM_CLASSES;

    logic [NUM_CLASSES-1:0] hit, is_new, clr;
    logic [CNT_W-1:0]       total [NUM_CLASSES];
    logic [CNT_W-1:0]       uniq  [NUM_CLASSES];
    logic [OVF_W-1:0]       ovf_set;
    logic [ADDR_W-1:0]      addr_q;
    logic                   sts_rst;
    ecc_status_t            sts_d, sts_q;

    assign hit[CLS_COR] = |cor_evt_i;
    assign hit[CLS_UNC] = |unc_evt_i;

    ecc_addr_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cor_hit_i  (hit[CLS_COR]),
        .cor_addr_i (cor_addr_i),
        .unc_hit_i  (hit[CLS_UNC]),
        .unc_addr_i (unc_addr_i),
        .addr_o     (addr_q),
        .cor_new_o  (is_new[CLS_COR]),
        .unc_new_o  (is_new[CLS_UNC])
    );

    for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
        assign clr[k] = reg_wr_i && (reg_sel_i == 2'(k + 1)) && (reg_wdata_i == '0);
        ecc_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk          (clk),
            .rst_n        (rst_n),
            .clr_i        (clr[k]),
            .hit_i        (hit[k]),
            .new_i        (is_new[k]),
            .total_o      (total[k]),
            .uniq_o       (uniq[k]),
            .total_wrap_o (ovf_set[2*k]),
            .uniq_wrap_o  (ovf_set[2*k+1])
        );
    end

    assign sts_rst = reg_wr_i && (ecc_reg_e'(reg_sel_i) == REG_STATUS)
                     && reg_wdata_i[STS_RESET_BIT];

    always_comb begin
        sts_d     = sts_rst ? '0 : sts_q;
        sts_d.cor = sts_d.cor | cor_evt_i;
        sts_d.unc = sts_d.unc | unc_evt_i;
        sts_d.ovf = sts_d.ovf | ovf_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign irq_cor_o = (|sts_q.cor) || (|sts_q.ovf[2*CLS_COR +: 2]);
    assign irq_unc_o = (|sts_q.unc) || (|sts_q.ovf[2*CLS_UNC +: 2]);

    always_comb begin
        reg_rdata_o = '0;
        case (ecc_reg_e'(reg_sel_i))
            REG_STATUS: begin
                for (int i = 0; i < NUM_STAGES; i++) begin
                    reg_rdata_o[2*i]   = sts_q.unc[i];
                    reg_rdata_o[2*i+1] = sts_q.cor[i];
                end
                reg_rdata_o[STS_OVF_LSB +: OVF_W] = sts_q.ovf;
            end
            REG_CORCNT: reg_rdata_o = {FIELD_W'(uniq[CLS_COR]), FIELD_W'(total[CLS_COR])};
            REG_UNCCNT: reg_rdata_o = {FIELD_W'(uniq[CLS_UNC]), FIELD_W'(total[CLS_UNC])};
            default:    reg_rdata_o = 32'(addr_q);
        endcase
    end

    // R7: overflow flags never drop without a status reset
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_rst |=> ((sts_q.ovf & $past(sts_q.ovf)) == $past(sts_q.ovf)));
    // R10: both interrupts fall after a quiet status reset
    p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rst && !(|cor_evt_i) && !(|unc_evt_i)) |=> (!irq_cor_o && !irq_unc_o));
    // R2: a corrected event raises the corrected interrupt
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|cor_evt_i) |=> irq_cor_o);
    // R9: command bit never reads back
    p_cmd_reads0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_reg_e'(reg_sel_i) == REG_STATUS) |-> !reg_rdata_o[STS_RESET_BIT]);
endmodule

// File: tb/ecc_err_logger_tb.sv
module ecc_err_logger_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cor_evt = '0, unc_evt = '0;
    logic [31:0] cor_addr = '0, unc_addr = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_cor, irq_unc;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    ecc_err_logger u_dut (
        .clk(clk), .rst_n(rst_n),
        .cor_evt_i(cor_evt), .cor_addr_i(cor_addr),
        .unc_evt_i(unc_evt), .unc_addr_i(unc_addr),
        .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_cor_o(irq_cor), .irq_unc_o(irq_unc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_sel = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse(input logic [2:0] c, input logic [31:0] ca,
                         input logic [2:0] u, input logic [31:0] ua);
        @(negedge clk);
        cor_evt = c; cor_addr = ca; unc_evt = u; unc_addr = ua;
        @(negedge clk);
        cor_evt = '0; unc_evt = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 4; a++) rd_chk("R1 reg after reset", 2'(a), 32'h0);
        chk("R1 irq_cor after reset", {31'b0, irq_cor}, 32'h0);
        chk("R1 irq_unc after reset", {31'b0, irq_unc}, 32'h0);
    endtask

    task automatic t_stage_bits();
        pulse(3'b010, 32'h100, 3'b000, 32'h0);
        rd_chk("R2 corrected tag flag bit3", 2'd0, 32'h0000_0008);
        chk("R10 irq_cor raised", {31'b0, irq_cor}, 32'h1);
        chk("R10 irq_unc quiet", {31'b0, irq_unc}, 32'h0);
        pulse(3'b000, 32'h0, 3'b100, 32'h200);
        rd_chk("R2 uncorrected data flag bit4 sticky", 2'd0, 32'h0000_0018);
        chk("R10 irq_unc raised", {31'b0, irq_unc}, 32'h1);
        rd_chk("R5 latest address", 2'd3, 32'h200);
        rd_chk("R3 corrected count layout", 2'd1, 32'h0001_0001);
        rd_chk("R3 uncorrected count layout", 2'd2, 32'h0001_0001);
    endtask

    task automatic t_unique();
        pulse(3'b001, 32'h200, 3'b000, 32'h0);
        rd_chk("R4 repeat address not unique", 2'd1, 32'h0001_0002);
        pulse(3'b001, 32'h200, 3'b000, 32'h0);
        rd_chk("R4 repeat address again", 2'd1, 32'h0001_0003);
        pulse(3'b001, 32'h300, 3'b000, 32'h0);
        rd_chk("R4 new address unique", 2'd1, 32'h0002_0004);
    endtask

    task automatic t_same_cycle();
        pulse(3'b001, 32'h400, 3'b001, 32'h500);
        rd_chk("R6 corrected counted", 2'd1, 32'h0003_0005);
        rd_chk("R6 uncorrected counted", 2'd2, 32'h0002_0002);
        rd_chk("R5 uncorrected address priority", 2'd3, 32'h500);
        pulse(3'b111, 32'h500, 3'b000, 32'h0);
        rd_chk("R3 multi-stage cycle counts once", 2'd1, 32'h0003_0006);
        rd_chk("R2 all stage flags", 2'd0, 32'h0000_003B);
    endtask

    task automatic t_clear_counts();
        wr(2'd1, 32'h1234);
        rd_chk("R8 nonzero write ignored", 2'd1, 32'h0003_0006);
        wr(2'd1, 32'h0);
        rd_chk("R8 corrected cleared", 2'd1, 32'h0);
        rd_chk("R8 uncorrected untouched", 2'd2, 32'h0002_0002);
        wr(2'd2, 32'h0);
        rd_chk("R8 uncorrected cleared", 2'd2, 32'h0);
    endtask

    task automatic t_addr_ro();
        wr(2'd3, 32'hDEAD);
        rd_chk("R11 address write ignored", 2'd3, 32'h500);
    endtask

    task automatic t_status_reset();
        wr(2'd0, 32'h0000_003F);
        rd_chk("R9 write without command bit ignored", 2'd0, 32'h0000_003B);
        wr(2'd0, 32'h4000_0000);
        rd_chk("R9 status cleared and bit30 reads 0", 2'd0, 32'h0);
        chk("R10 irq_cor dropped", {31'b0, irq_cor}, 32'h0);
        chk("R10 irq_unc dropped", {31'b0, irq_unc}, 32'h0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 65535; i++) begin
            @(negedge clk);
            cor_evt = 3'b001;
            cor_addr = i[0] ? 32'hA1 : 32'hA0;
        end
        @(negedge clk);
        cor_evt = '0;
        rd_chk("R7 counters at max", 2'd1, 32'hFFFF_FFFF);
        rd_chk("R7 no overflow before wrap", 2'd0, 32'h0000_0002);
        pulse(3'b001, 32'hA1, 3'b000, 32'h0);
        rd_chk("R7 counters wrapped", 2'd1, 32'h0);
        rd_chk("R7 overflow flags bits16 17", 2'd0, 32'h0003_0002);
        wr(2'd1, 32'h0);
        rd_chk("R7 overflow survives count clear", 2'd0, 32'h0003_0002);
        chk("R10 irq_cor from overflow", {31'b0, irq_cor}, 32'h1);
        wr(2'd0, 32'h4000_0000);
        rd_chk("R9 overflow cleared by reset", 2'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stage_bits();
        t_unique();
        t_same_cycle();
        t_clear_counts();
        t_addr_ro();
        t_status_reset();
        t_wrap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule